// File: doc/BRIEF.md
# Strided and Gather Address Generator

This block sits beside one slice's load/store unit and turns a single load/store sub-operation into a train of memory requests, one per repetition. A descriptor names the mode, the transfer size, the repeat count and the register operands. In strided mode each address is the sum of two scalar registers, the base and the stride, and the sum is written back into the base register so the following access moves on by one stride. In gather and scatter modes each address is one element of an index vector register plus a scalar offset, and the element pointer moves on by one per request. Scatter also fetches the matching store datum from a source vector register in the same step.

The register files live outside the block. It drives their read indices and reads the data combinationally. Requests go out under a valid/ready handshake. A stall freezes the address, the pointers and the scalar write-back.

Top module: `ldst_addr_gen`

## Requirements
- R1: After reset, op_ready is 1, mem_valid is 0 and sr_wr_en is 0.
- R2: Mode code 0 (strided): each request address equals sr[base] + sr[stride]. On each accepted request that sum is written to sr[base], so the k-th address (k from 1) is base0 + k*stride, and afterwards sr[base] holds base0 + rep*stride.
- R3: Mode code 1 or 3 (gather load): the address equals element ptr of index vector register plus sr[offset]. The pointer starts at 0 and advances by one per accepted request. No scalar register is written.
- R4: Mode code 2 (scatter): addresses follow R3, mem_write is 1, and mem_wdata equals element ptr of the source vector register on the same request.
- R5: Exactly op_rep requests are issued per descriptor. A repeat count of 0 issues none and leaves op_ready at 1.
- R6: While mem_valid is 1 and mem_ready is 0, the address, size, write flag and data are held, and sr_wr_en stays 0.
- R7: mem_size carries the descriptor size code, where bytes = 8 << code. Codes 6 and 7 are treated as code 5 (256 bytes).
- R8: mem_misalign is 1 exactly when mem_valid is 1 and the address is not a multiple of the transfer size in bytes. The request is still issued.
- R9: op_ready is 1 only when no operation is in progress. A descriptor is taken when op_valid and op_ready are both 1, and for a nonzero count mem_valid rises in the next cycle.
- R10: The element pointer wraps modulo VLEN when the repeat count exceeds the vector length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Descriptor offered |
| op_ready | output | 1 | Block idle, descriptor accepted |
| op_mode | input | 2 | 0 strided, 1 gather, 2 scatter, 3 gather |
| op_size | input | 3 | Size code, bytes = 8 << code |
| op_rep | input | REP_W | Repeat count |
| op_sa | input | SIDX_W | Base scalar index (strided) |
| op_sb | input | SIDX_W | Stride or offset scalar index |
| op_vidx | input | VIDX_W | Index vector register |
| op_vsrc | input | VIDX_W | Scatter data vector register |
| sr_rd_a_idx | output | SIDX_W | Scalar read port A index |
| sr_rd_a_data | input | ADDR_W | Scalar read port A data |
| sr_rd_b_idx | output | SIDX_W | Scalar read port B index |
| sr_rd_b_data | input | ADDR_W | Scalar read port B data |
| sr_wr_en | output | 1 | Scalar write-back enable |
| sr_wr_idx | output | SIDX_W | Scalar write-back index |
| sr_wr_data | output | ADDR_W | Scalar write-back value |
| vi_reg | output | VIDX_W | Index vector register read |
| vi_elem | output | ELEM_W | Index vector element pointer |
| vi_data | input | ADDR_W | Index element value |
| vd_reg | output | VIDX_W | Data vector register read |
| vd_elem | output | ELEM_W | Data vector element pointer |
| vd_data | input | DATA_W | Data element value |
| mem_valid | output | 1 | Request valid |
| mem_ready | input | 1 | Request accepted |
| mem_addr | output | ADDR_W | Request address |
| mem_size | output | 3 | Clamped size code |
| mem_write | output | 1 | Store request |
| mem_wdata | output | DATA_W | Store datum |
| mem_misalign | output | 1 | Address not aligned to size |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 32 scalar and 32 vector registers, 32 elements per vector and a 6-bit repeat count. With those values a count of 40 runs the element pointer through one wrap, and the top size code plus the two clamped codes can be exercised. Stalls come from a ready pattern that drops one cycle in three.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

    typedef enum logic [1:0] {
        LSAG_STRIDE  = 2'd0,
        LSAG_GATHER  = 2'd1,
        LSAG_SCATTER = 2'd2,
        LSAG_GATHER2 = 2'd3
    } lsag_mode_e;

    localparam int          LSAG_BASE_LOG = 3;
    localparam logic [2:0]  LSAG_SIZE_MAX = 3'd5;

    function automatic logic [2:0] lsag_clamp_size(input logic [2:0] code);
        return (code > LSAG_SIZE_MAX) ? LSAG_SIZE_MAX : code;
    endfunction

endpackage

// File: rtl/lsag_addr_calc.sv
module lsag_addr_calc #(
    parameter int ADDR_W = 32
) (
    input  logic              strided,
    input  logic [ADDR_W-1:0] scal_a,
    input  logic [ADDR_W-1:0] scal_b,
    input  logic [ADDR_W-1:0] vec_elem,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] lhs;

    always_comb begin
        lhs  = strided ? scal_a : vec_elem;
        addr = lhs + scal_b;
    end
endmodule

// File: rtl/lsag_align_chk.sv
module lsag_align_chk
    import lsag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [2:0]        size_code,
    input  logic [ADDR_W-1:0] addr,
    output logic              misalign
);
    localparam int MASK_W = LSAG_BASE_LOG + int'(LSAG_SIZE_MAX);

    logic [MASK_W-1:0] low_mask;

    generate
        for (genvar i = 0; i < MASK_W; i++) begin : g_mask
            assign low_mask[i] = (int'(size_code) + LSAG_BASE_LOG) > i;
        end
    endgenerate

    assign misalign = |(addr[MASK_W-1:0] & low_mask);
endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
    import lsag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int SREG_N = 32,
    parameter int VREG_N = 32,
    parameter int VLEN   = 32,
    parameter int REP_W  = 6,
    localparam int SIDX_W = $clog2(SREG_N),
    localparam int VIDX_W = $clog2(VREG_N),
    localparam int ELEM_W = $clog2(VLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [1:0]        op_mode,
    input  logic [2:0]        op_size,
    input  logic [REP_W-1:0]  op_rep,
    input  logic [SIDX_W-1:0] op_sa,
    input  logic [SIDX_W-1:0] op_sb,
    input  logic [VIDX_W-1:0] op_vidx,
    input  logic [VIDX_W-1:0] op_vsrc,
    output logic [SIDX_W-1:0] sr_rd_a_idx,
    input  logic [ADDR_W-1:0] sr_rd_a_data,
    output logic [SIDX_W-1:0] sr_rd_b_idx,
    input  logic [ADDR_W-1:0] sr_rd_b_data,
    output logic              sr_wr_en,
    output logic [SIDX_W-1:0] sr_wr_idx,
    output logic [ADDR_W-1:0] sr_wr_data,
    output logic [VIDX_W-1:0] vi_reg,
    output logic [ELEM_W-1:0] vi_elem,
    input  logic [ADDR_W-1:0] vi_data,
    output logic [VIDX_W-1:0] vd_reg,
    output logic [ELEM_W-1:0] vd_elem,
    input  logic [DATA_W-1:0] vd_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [2:0]        mem_size,
    output logic              mem_write,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_misalign
);

    typedef struct packed {
        logic              busy;
        lsag_mode_e        mode;
        logic [2:0]        size;
        logic [REP_W-1:0]  left;
        logic [SIDX_W-1:0] sa;
        logic [SIDX_W-1:0] sb;
        logic [VIDX_W-1:0] vidx;
        logic [VIDX_W-1:0] vsrc;
        logic [ELEM_W-1:0] ptr;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic              strided;
    logic              fire;
    logic [ADDR_W-1:0] addr;
    logic              mis;

    assign strided = (st_q.mode == LSAG_STRIDE);
    assign fire    = st_q.busy && mem_ready;

    lsag_addr_calc #(.ADDR_W(ADDR_W)) u_calc (
        .strided  (strided),
        .scal_a   (sr_rd_a_data),
        .scal_b   (sr_rd_b_data),
        .vec_elem (vi_data),
        .addr     (addr)
    );

    lsag_align_chk #(.ADDR_W(ADDR_W)) u_align (
        .size_code (st_q.size),
        .addr      (addr),
        .misalign  (mis)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (op_valid && (op_rep != '0)) begin
                st_d.busy = 1'b1;
                st_d.mode = lsag_mode_e'(op_mode);
                st_d.size = lsag_clamp_size(op_size);
                st_d.left = op_rep;
                st_d.sa   = op_sa;
                st_d.sb   = op_sb;
                st_d.vidx = op_vidx;
                st_d.vsrc = op_vsrc;
                st_d.ptr  = '0;
            end
        end else if (fire) begin
            st_d.left = st_q.left - REP_W'(1);
            if (!strided) begin
                st_d.ptr = st_q.ptr + ELEM_W'(1);
            end
            if (st_q.left == REP_W'(1)) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        op_ready     = !st_q.busy;
        sr_rd_a_idx  = st_q.sa;
        sr_rd_b_idx  = st_q.sb;
        vi_reg       = st_q.vidx;
        vi_elem      = st_q.ptr;
        vd_reg       = st_q.vsrc;
        vd_elem      = st_q.ptr;
        sr_wr_en     = fire && strided;
        sr_wr_idx    = st_q.sa;
        sr_wr_data   = addr;
        mem_valid    = st_q.busy;
        mem_addr     = addr;
        mem_size     = st_q.size;
        mem_write    = st_q.busy && (st_q.mode == LSAG_SCATTER);
        mem_wdata    = vd_data;
        mem_misalign = st_q.busy && mis;
    end

endmodule

// File: rtl/lsag_checker.sv
module lsag_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int REP_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_ready,
    input logic [REP_W-1:0]  op_rep,
    input logic              sr_wr_en,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [2:0]        mem_size,
    input logic              mem_write,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_misalign
);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_size)
                                       && $stable(mem_write) && $stable(mem_wdata)));

    assert_no_wb_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_en |-> (mem_valid && mem_ready));

    assert_ready_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready |-> !mem_valid);

    assert_start_next_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && (op_rep != '0)) |=> mem_valid);

    assert_misalign_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_misalign |-> mem_valid);

    assert_size_clamped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_size <= 3'd5));

    assert_write_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_write |-> mem_valid);

endmodule

bind ldst_addr_gen lsag_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .REP_W  (REP_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_ready     (op_ready),
    .op_rep       (op_rep),
    .sr_wr_en     (sr_wr_en),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr),
    .mem_size     (mem_size),
    .mem_write    (mem_write),
    .mem_wdata    (mem_wdata),
    .mem_misalign (mem_misalign)
);

// File: tb/ldst_addr_gen_tb.sv
module ldst_addr_gen_tb;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 64;
    localparam int VLEN   = 32;
    localparam int REP_W  = 6;

    logic clk = 0;
    logic rst_n = 0;
    always #2.5 clk = ~clk;

    logic              op_valid = 0;
    logic              op_ready;
    logic [1:0]        op_mode = 0;
    logic [2:0]        op_size = 0;
    logic [REP_W-1:0]  op_rep = 0;
    logic [4:0]        op_sa = 0, op_sb = 0, op_vidx = 0, op_vsrc = 0;
    logic [4:0]        sr_rd_a_idx, sr_rd_b_idx, sr_wr_idx;
    logic [ADDR_W-1:0] sr_rd_a_data, sr_rd_b_data, sr_wr_data;
    logic              sr_wr_en;
    logic [4:0]        vi_reg, vd_reg;
    logic [4:0]        vi_elem, vd_elem;
    logic [ADDR_W-1:0] vi_data;
    logic [DATA_W-1:0] vd_data;
    logic              mem_valid, mem_write, mem_misalign;
    logic              mem_ready = 1;
    logic [ADDR_W-1:0] mem_addr;
    logic [2:0]        mem_size;
    logic [DATA_W-1:0] mem_wdata;

    ldst_addr_gen u_dut (.*);

    // scalar register file model
    logic [ADDR_W-1:0] srf [32];
    logic              tb_wr = 0;
    logic [4:0]        tb_idx = 0;
    logic [ADDR_W-1:0] tb_val = 0;
    always @(posedge clk) begin
        if (sr_wr_en)   srf[sr_wr_idx] <= sr_wr_data;
        else if (tb_wr) srf[tb_idx] <= tb_val;
    end
    assign sr_rd_a_data = srf[sr_rd_a_idx];
    assign sr_rd_b_data = srf[sr_rd_b_idx];

    function automatic logic [ADDR_W-1:0] vi_val(input int r, input int e);
        return ADDR_W'(32'h0010_0000 * r + e * 64);
    endfunction
    function automatic logic [DATA_W-1:0] vd_val(input int r, input int e);
        return 64'hD000_0000_0000_0000 | DATA_W'(r * 256 + e);
    endfunction
    assign vi_data = vi_val(int'(vi_reg), int'(vi_elem));
    assign vd_data = vd_val(int'(vd_reg), int'(vd_elem));

    // ready pattern
    int cyc = 0;
    bit stall_mode = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 mem_ready <= stall_mode ? ((cyc % 3) != 0) : 1'b1;
    end

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [2:0]        size;
        logic              mis;
        string             req;
    } exp_t;
    exp_t exq[$];

    logic [ADDR_W-1:0] shadow [32];

    // monitor
    bit                prev_stall = 0;
    logic [ADDR_W-1:0] prev_addr;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall && mem_valid)
                chk(mem_addr == prev_addr, "R6", "held address", 64'(mem_addr), 64'(prev_addr));
            if (mem_valid && !mem_ready)
                chk(!sr_wr_en, "R6", "write-back during stall", 64'(sr_wr_en), 64'd0);
            prev_stall = mem_valid && !mem_ready;
            prev_addr  = mem_addr;
            if (mem_valid && mem_ready) begin
                if (exq.size() == 0) begin
                    chk(0, "R5", "unexpected request", 64'(mem_addr), 64'd0);
                end else begin
                    exp_t e;
                    e = exq.pop_front();
                    chk(mem_addr == e.addr, e.req, "address", 64'(mem_addr), 64'(e.addr));
                    chk(mem_write == e.wr, "R4", "write flag", 64'(mem_write), 64'(e.wr));
                    if (e.wr)
                        chk(mem_wdata == e.wdata, "R4", "store data", mem_wdata, e.wdata);
                    chk(mem_size == e.size, "R7", "size code", 64'(mem_size), 64'(e.size));
                    chk(mem_misalign == e.mis, "R8", "misalign", 64'(mem_misalign), 64'(e.mis));
                end
            end
        end
    end

    task automatic set_sreg(input int idx, input logic [ADDR_W-1:0] v);
        @(posedge clk) #1;
        tb_wr = 1; tb_idx = 5'(idx); tb_val = v;
        @(posedge clk) #1;
        tb_wr = 0;
        shadow[idx] = v;
    endtask

    task automatic run_op(input int mode, input int size, input int rep,
                          input int sa, input int sb, input int vidx, input int vsrc);
        int          csz;
        logic [31:0] mask;
        logic [ADDR_W-1:0] base, a;
        string req;
        csz  = (size > 5) ? 5 : size;
        mask = (32'd8 << csz) - 1;
        base = shadow[sa];
        req  = (mode == 0) ? "R2" : ((mode == 2) ? "R4" : ((rep > VLEN) ? "R10" : "R3"));
        for (int k = 0; k < rep; k++) begin
            exp_t e;
            if (mode == 0) a = base + ADDR_W'(k + 1) * shadow[sb];
            else           a = vi_val(vidx, k % VLEN) + shadow[sb];
            e.addr  = a;
            e.wr    = (mode == 2);
            e.wdata = vd_val(vsrc, k % VLEN);
            e.size  = 3'(csz);
            e.mis   = (a & mask) != 0;
            e.req   = req;
            exq.push_back(e);
        end
        @(posedge clk) #1;
        op_valid = 1; op_mode = 2'(mode); op_size = 3'(size); op_rep = REP_W'(rep);
        op_sa = 5'(sa); op_sb = 5'(sb); op_vidx = 5'(vidx); op_vsrc = 5'(vsrc);
        @(posedge clk) #1;
        op_valid = 0;
        @(negedge clk);
        if (rep > 0) begin
            chk(mem_valid == 1, "R9", "valid after accept", 64'(mem_valid), 64'd1);
            chk(op_ready == 0, "R9", "ready while busy", 64'(op_ready), 64'd0);
        end else begin
            chk(mem_valid == 0, "R5", "zero count valid", 64'(mem_valid), 64'd0);
            chk(op_ready == 1, "R5", "zero count ready", 64'(op_ready), 64'd1);
        end
        while (!op_ready) @(negedge clk);
        chk(exq.size() == 0, "R5", "requests outstanding", 64'(exq.size()), 64'd0);
        exq.delete();
        if (mode == 0) begin
            @(negedge clk);
            a = base + ADDR_W'(rep) * shadow[sb];
            chk(srf[sa] == a, "R2", "final base", 64'(srf[sa]), 64'(a));
            shadow[sa] = a;
        end else if (sa != sb) begin
            chk(srf[sa] == shadow[sa], "R3", "scalar untouched", 64'(srf[sa]), 64'(shadow[sa]));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin srf[i] = '0; shadow[i] = '0; end
        repeat (3) @(posedge clk);
        #1;
        chk(op_ready == 1, "R1", "reset ready", 64'(op_ready), 64'd1);
        chk(mem_valid == 0, "R1", "reset valid", 64'(mem_valid), 64'd0);
        chk(sr_wr_en == 0, "R1", "reset write", 64'(sr_wr_en), 64'd0);
        rst_n = 1;

        set_sreg(1, 32'h0000_1000);
        set_sreg(2, 32'h0000_0040);
        set_sreg(3, 32'h0000_0100);
        set_sreg(4, 32'h0000_0004);
        set_sreg(5, 32'h0000_2008);

        run_op(0, 0, 8, 1, 2, 0, 0);        // R2 strided, 8-byte, no stall
        run_op(1, 0, 10, 6, 3, 7, 0);       // R3 gather
        run_op(2, 1, 9, 6, 3, 4, 9);        // R4 scatter
        run_op(0, 0, 0, 1, 2, 0, 0);        // R5 zero count
        run_op(1, 0, 5, 6, 4, 2, 0);        // R8 gather misaligned (offset 4)
        run_op(0, 5, 3, 5, 3, 0, 0);        // R8 256-byte misaligned base
        run_op(1, 7, 4, 6, 3, 1, 0);        // R7 clamped size code
        run_op(3, 2, 2, 6, 3, 5, 0);        // R3 mode code 3
        stall_mode = 1;
        run_op(0, 0, 12, 1, 2, 0, 0);       // R6 strided with stalls
        run_op(2, 3, 11, 6, 3, 8, 12);      // R6 scatter with stalls
        run_op(1, 0, 40, 6, 3, 3, 0);       // R10 pointer wrap
        stall_mode = 0;

        repeat (4) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule